// File: doc/BRIEF.md
# Banked Byte Data Memory with Fast-Access Window

This block is the data memory of a small 8-bit processor core. The core presents an 8-bit operand and an access bit. With the access bit clear, the 12-bit effective address joins a 4-bit bank register to the operand. With the access bit set, the operand goes through a fixed 256-byte fast window that never consults the bank register. The low part of this window lands in the bottom of bank 0 and the high part lands in the special register area at the top of the space. The bank register has its own load strobe, and the core can also read and write it at a special register address.

Behind the address logic sit three regions. The first is general-purpose RAM from address zero up to a parameterised top. The second is a block of special registers at the top of the space. The gap between them reads as zero and ignores writes. A second port lets a USB DMA engine read and write the general-purpose RAM in the same cycle as the core. When both ports write one location in one cycle, the DMA value is kept and the core is told. While the USB enable is high, one bank holds buffer descriptors owned by the DMA engine. While it is low, that bank is plain RAM.

Top module: `banked_data_mem`

## Requirements
- R1: With core_acc = 0 the effective address is {bank register, core_opnd}, so one operand value reaches a different byte for each bank value.
- R2: With core_acc = 1, operands 0x00 to 0x5F map to addresses 0x000 to 0x05F whatever the bank register holds.
- R3: With core_acc = 1, operands 0x60 to 0xFF map to addresses 0xF60 to 0xFFF whatever the bank register holds.
- R4: Addresses above the RAM top (default 0xDFF) and below 0xF60 read as 0x00 on both ports, and writes to them are ignored.
- R5: The bank register resets to 0 and loads bsr_in at the edge where bsr_ld is high. It reads at address 0xFE0 as {4'b0, bank}. A core write to 0xFE0 loads bits 3:0. If bsr_ld and such a write occur in the same cycle, bsr_ld wins.
- R6: Special registers at 0xF60 to 0xFFF, other than 0xFE0, hold full bytes and reset to 0x00.
- R7: The core address is registered at a clock edge where core_en is high. core_rdata is combinational from that registered address, and it already shows a write made at the same edge. While core_en is low the address is held.
- R8: With usb_en high, the DMA port reads and writes RAM at 0x000 up to the RAM top in the same cycle as core accesses elsewhere. The DMA read address is registered like the core's. DMA addresses outside RAM read 0x00 and ignore writes.
- R9: With usb_en low, DMA requests are ignored and dma_rdata is 0x00.
- R10: If the core and the DMA port write the same RAM address at one edge, the DMA byte is stored, and core_conflict is high for the following cycle only.
- R11: Addresses 0xD00 to 0xDFF ignore core writes while usb_en is high, though the core still reads them and the DMA port still writes them. With usb_en low they behave as ordinary RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Core access strobe |
| core_we | input | 1 | Core write when high |
| core_acc | input | 1 | Use the fast-access window |
| core_opnd | input | 8 | Instruction operand |
| core_wdata | input | 8 | Core write byte |
| core_rdata | output | 8 | Core read byte |
| core_conflict | output | 1 | Core write lost to a DMA write last edge |
| bsr_ld | input | 1 | Bank register load strobe |
| bsr_in | input | 4 | Bank register load value |
| usb_en | input | 1 | USB enable |
| dma_en | input | 1 | DMA access strobe |
| dma_we | input | 1 | DMA write when high |
| dma_addr | input | 12 | DMA byte address |
| dma_wdata | input | 8 | DMA write byte |
| dma_rdata | output | 8 | DMA read byte |

## Verification
The hardest state to reach is a same-address collision, because the core can only name an address through the bank register or the window, while the DMA port names it directly. The bench first loads a bank value. At one falling edge it then drives a banked core write and a DMA write to the matching 12-bit address, and afterwards looks at core_conflict and the stored byte over two cycles. The descriptor bank is also toggled in and out of USB ownership between writes, so that a blocked core write can be told apart from one that landed.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    typedef enum logic [1:0] {
        RG_HOLE = 2'd0,
        RG_GPR  = 2'd1,
        RG_SFR  = 2'd2
    } region_e;

endpackage

// File: rtl/bdm_ea_gen.sv
module bdm_ea_gen #(
    parameter int BANK_W    = 4,
    parameter int OPND_W    = 8,
    parameter int ACC_SPLIT = 'h60
) (
    input  logic [BANK_W-1:0]        bsr,
    input  logic                     acc,
    input  logic [OPND_W-1:0]        opnd,
    output logic [BANK_W+OPND_W-1:0] ea
);
    localparam logic [OPND_W-1:0] SPLIT_V = OPND_W'(ACC_SPLIT);

    logic [BANK_W-1:0] bank_sel;

    // Window: low operands go to bank 0, the rest to the top bank.
    always_comb begin
        if (!acc) begin
            bank_sel = bsr;
        end else if (opnd < SPLIT_V) begin
            bank_sel = '0;
        end else begin
            bank_sel = '1;
        end
        ea = {bank_sel, opnd};
    end
endmodule

// File: rtl/bdm_region.sv
module bdm_region
    import bdm_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int GPR_TOP   = 'hDFF,
    parameter int SFR_BASE  = 'hF60,
    parameter int DESC_BASE = 'hD00,
    parameter int DESC_TOP  = 'hDFF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rg,
    output logic              desc
);
    localparam logic [ADDR_W-1:0] TOP_V   = ADDR_W'(GPR_TOP);
    localparam logic [ADDR_W-1:0] SFR_V   = ADDR_W'(SFR_BASE);
    localparam logic [ADDR_W-1:0] DBASE_V = ADDR_W'(DESC_BASE);
    localparam logic [ADDR_W-1:0] DTOP_V  = ADDR_W'(DESC_TOP);

    always_comb begin
        if (addr >= SFR_V) begin
            rg = RG_SFR;
        end else if (addr <= TOP_V) begin
            rg = RG_GPR;
        end else begin
            rg = RG_HOLE;
        end
        desc = (addr >= DBASE_V) && (addr <= DTOP_V);
    end
endmodule

// File: rtl/bdm_sfr_file.sv
module bdm_sfr_file #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int SFR_BASE = 'hF60,
    parameter int BSR_ADDR = 'hFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bsr_ld,
    input  logic [BANK_W-1:0] bsr_in,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [BANK_W-1:0] bsr
);
    localparam int SFR_N = (1 << ADDR_W) - SFR_BASE;
    localparam int IDX_W = $clog2(SFR_N);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(SFR_BASE);
    localparam logic [ADDR_W-1:0] BSR_V  = ADDR_W'(BSR_ADDR);

    typedef struct packed {
        logic [SFR_N-1:0][DATA_W-1:0] regs;
        logic [BANK_W-1:0]            bsr;
    } sfr_st_t;

    sfr_st_t st_d, st_q;
    logic [ADDR_W-1:0] woff, roff;
    logic [IDX_W-1:0]  widx, ridx;

    always_comb begin
        woff = waddr - BASE_V;
        roff = raddr - BASE_V;
        widx = woff[IDX_W-1:0];
        ridx = roff[IDX_W-1:0];
        st_d = st_q;
        if (we) begin
            if (waddr == BSR_V) begin
                st_d.bsr = wdata[BANK_W-1:0];
            end else begin
                st_d.regs[widx] = wdata;
            end
        end
        // The strobe outranks a bus write to the bank register.
        if (bsr_ld) begin
            st_d.bsr = bsr_in;
        end
        if (raddr == BSR_V) begin
            rdata = DATA_W'(st_q.bsr);
        end else begin
            rdata = st_q.regs[ridx];
        end
        bsr = st_q.bsr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_ld |=> bsr == $past(bsr_in)); // R5

    AST_SFR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != BSR_V) |=> (raddr != $past(waddr)) || (rdata == $past(wdata))); // R6
endmodule

// File: rtl/bdm_gpr_ram.sv
module bdm_gpr_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 'hE00
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [ADDR_W-1:0] a_raddr,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign a_rdata = mem[a_raddr];
    assign b_rdata = mem[b_raddr];

    // Port B is written last, so it takes a shared address.
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_waddr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_waddr] <= b_wdata;
        end
    end

    AST_B_WINS: assert property (@(posedge clk)
        (a_we && b_we && a_waddr == b_waddr) |=> mem[$past(b_waddr)] == $past(b_wdata)); // R10
endmodule

// File: rtl/banked_data_mem.sv
module banked_data_mem
    import bdm_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int OPND_W    = 8,
    parameter int DATA_W    = 8,
    parameter int GPR_TOP   = 'hDFF,
    parameter int SFR_BASE  = 'hF60,
    parameter int ACC_SPLIT = 'h60,
    parameter int BSR_ADDR  = 'hFE0,
    parameter int DESC_BASE = 'hD00,
    parameter int DESC_TOP  = 'hDFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_en,
    input  logic                     core_we,
    input  logic                     core_acc,
    input  logic [OPND_W-1:0]        core_opnd,
    input  logic [DATA_W-1:0]        core_wdata,
    output logic [DATA_W-1:0]        core_rdata,
    output logic                     core_conflict,
    input  logic                     bsr_ld,
    input  logic [BANK_W-1:0]        bsr_in,
    input  logic                     usb_en,
    input  logic                     dma_en,
    input  logic                     dma_we,
    input  logic [BANK_W+OPND_W-1:0] dma_addr,
    input  logic [DATA_W-1:0]        dma_wdata,
    output logic [DATA_W-1:0]        dma_rdata
);
    localparam int ADDR_W = BANK_W + OPND_W;
    localparam int DEPTH  = GPR_TOP + 1;
    localparam logic [ADDR_W-1:0] TOP_V   = ADDR_W'(GPR_TOP);
    localparam logic [ADDR_W-1:0] SFR_V   = ADDR_W'(SFR_BASE);
    localparam logic [ADDR_W-1:0] BSR_V   = ADDR_W'(BSR_ADDR);
    localparam logic [OPND_W-1:0] SPLIT_V = OPND_W'(ACC_SPLIT);

    typedef struct packed {
        logic [ADDR_W-1:0] core_addr;
        region_e           core_rg;
        logic [ADDR_W-1:0] dma_addr;
        logic              dma_ok;
        logic              conflict;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [BANK_W-1:0] bsr;
    logic [ADDR_W-1:0] ea;
    region_e           ea_rg;
    logic              ea_desc;
    logic              core_wr, gpr_a_we, sfr_we, dma_req, gpr_b_we;
    logic [DATA_W-1:0] gpr_a_rd, gpr_b_rd, sfr_rd;

    bdm_ea_gen #(
        .BANK_W   (BANK_W),
        .OPND_W   (OPND_W),
        .ACC_SPLIT(ACC_SPLIT)
    ) u_ea (
        .bsr (bsr),
        .acc (core_acc),
        .opnd(core_opnd),
        .ea  (ea)
    );

    bdm_region #(
        .ADDR_W   (ADDR_W),
        .GPR_TOP  (GPR_TOP),
        .SFR_BASE (SFR_BASE),
        .DESC_BASE(DESC_BASE),
        .DESC_TOP (DESC_TOP)
    ) u_rg (
        .addr(ea),
        .rg  (ea_rg),
        .desc(ea_desc)
    );

    always_comb begin
        core_wr  = core_en && core_we;
        gpr_a_we = core_wr && (ea_rg == RG_GPR) && !(usb_en && ea_desc);
        sfr_we   = core_wr && (ea_rg == RG_SFR);
        dma_req  = dma_en && usb_en && (dma_addr <= TOP_V);
        gpr_b_we = dma_req && dma_we;

        st_d = st_q;
        if (core_en) begin
            st_d.core_addr = ea;
            st_d.core_rg   = ea_rg;
        end
        if (dma_en) begin
            st_d.dma_addr = dma_addr;
            st_d.dma_ok   = dma_req;
        end else begin
            st_d.dma_ok = st_q.dma_ok && usb_en;
        end
        st_d.conflict = gpr_a_we && gpr_b_we && (ea == dma_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.core_addr <= BSR_V;
            st_q.core_rg   <= RG_SFR;
            st_q.dma_addr  <= '0;
            st_q.dma_ok    <= 1'b0;
            st_q.conflict  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    bdm_gpr_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk    (clk),
        .a_we   (gpr_a_we),
        .a_waddr(ea),
        .a_wdata(core_wdata),
        .a_raddr(st_q.core_addr),
        .a_rdata(gpr_a_rd),
        .b_we   (gpr_b_we),
        .b_waddr(dma_addr),
        .b_wdata(dma_wdata),
        .b_raddr(st_q.dma_addr),
        .b_rdata(gpr_b_rd)
    );

    bdm_sfr_file #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BANK_W  (BANK_W),
        .SFR_BASE(SFR_BASE),
        .BSR_ADDR(BSR_ADDR)
    ) u_sfr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sfr_we),
        .waddr (ea),
        .wdata (core_wdata),
        .bsr_ld(bsr_ld),
        .bsr_in(bsr_in),
        .raddr (st_q.core_addr),
        .rdata (sfr_rd),
        .bsr   (bsr)
    );

    always_comb begin
        case (st_q.core_rg)
            RG_GPR:  core_rdata = gpr_a_rd;
            RG_SFR:  core_rdata = sfr_rd;
            default: core_rdata = '0;
        endcase
        dma_rdata     = st_q.dma_ok ? gpr_b_rd : '0;
        core_conflict = st_q.conflict;
    end

    AST_BANKED_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !core_acc) |=> st_q.core_addr == {$past(bsr), $past(core_opnd)}); // R1

    AST_WIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && core_acc && core_opnd < SPLIT_V) |=> st_q.core_addr[ADDR_W-1 -: BANK_W] == '0); // R2

    AST_WIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && core_acc && core_opnd >= SPLIT_V) |=> st_q.core_addr[ADDR_W-1 -: BANK_W] == '1); // R3

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.core_addr > TOP_V && st_q.core_addr < SFR_V) |-> core_rdata == '0); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_en && !dma_en && !bsr_ld) |=> $stable(core_rdata)); // R7

    AST_DMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_en |=> dma_rdata == '0); // R9

    AST_CONFLICT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        core_conflict |-> core_rdata == $past(dma_wdata)); // R10
endmodule

// File: tb/banked_data_mem_test.sv
module banked_data_mem_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       core_en, core_we, core_acc;
    logic [7:0] core_opnd, core_wdata, core_rdata;
    logic       core_conflict;
    logic       bsr_ld;
    logic [3:0] bsr_in;
    logic       usb_en, dma_en, dma_we;
    logic [11:0] dma_addr;
    logic [7:0] dma_wdata, dma_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    banked_data_mem uut (
        .clk(clk), .rst_n(rst_n),
        .core_en(core_en), .core_we(core_we), .core_acc(core_acc),
        .core_opnd(core_opnd), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_conflict(core_conflict),
        .bsr_ld(bsr_ld), .bsr_in(bsr_in), .usb_en(usb_en),
        .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        core_en = 0; core_we = 0; dma_en = 0; dma_we = 0; bsr_ld = 0;
    endtask

    task automatic set_bank(input logic [3:0] v);
        bsr_ld = 1; bsr_in = v; tick();
    endtask

    task automatic core_wr(input logic acc, input logic [7:0] op, input logic [7:0] d);
        core_en = 1; core_we = 1; core_acc = acc; core_opnd = op; core_wdata = d; tick();
    endtask

    task automatic core_rd(input logic acc, input logic [7:0] op);
        core_en = 1; core_we = 0; core_acc = acc; core_opnd = op; tick();
    endtask

    task automatic dma_wr(input logic [11:0] a, input logic [7:0] d);
        dma_en = 1; dma_we = 1; dma_addr = a; dma_wdata = d; tick();
    endtask

    task automatic dma_rd(input logic [11:0] a);
        dma_en = 1; dma_we = 0; dma_addr = a; tick();
    endtask

    task automatic t_reset();
        check("R5 reset bank readback", core_rdata, 8'h00);
        check("R10 reset conflict", {7'b0, core_conflict}, 8'h00);
        check("R9 reset dma_rdata", dma_rdata, 8'h00);
        core_rd(1, 8'h80);
        check("R6 reset SFR 0xF80", core_rdata, 8'h00);
    endtask

    task automatic t_banked();
        set_bank(4'h2); core_wr(0, 8'h34, 8'hA5);
        set_bank(4'h3); core_wr(0, 8'h34, 8'h5A);
        set_bank(4'h2); core_rd(0, 8'h34);
        check("R1 bank 2 byte", core_rdata, 8'hA5);
        set_bank(4'h3); core_rd(0, 8'h34);
        check("R1 bank 3 byte", core_rdata, 8'h5A);
        usb_en = 1; dma_rd(12'h234);
        check("R1 address seen by DMA", dma_rdata, 8'hA5);
        usb_en = 0;
    endtask

    task automatic t_win_low();
        set_bank(4'h7); core_wr(1, 8'h10, 8'hC3); core_wr(1, 8'h5F, 8'h3C);
        set_bank(4'h0); core_rd(0, 8'h10);
        check("R2 window 0x10 in bank 0", core_rdata, 8'hC3);
        core_rd(0, 8'h5F);
        check("R2 window edge 0x5F", core_rdata, 8'h3C);
    endtask

    task automatic t_win_high();
        set_bank(4'h5); core_wr(1, 8'h60, 8'h11); core_wr(1, 8'hFF, 8'h22);
        set_bank(4'hF); core_rd(0, 8'h60);
        check("R3 window 0x60 -> 0xF60", core_rdata, 8'h11);
        core_rd(0, 8'hFF);
        check("R3 window 0xFF -> 0xFFF", core_rdata, 8'h22);
        core_wr(1, 8'h70, 8'h99); core_rd(1, 8'h70);
        check("R6 SFR 0xF70 full byte", core_rdata, 8'h99);
        set_bank(4'h0); core_rd(0, 8'h60);
        check("R3 bank 0 0x60 untouched", core_rdata, 8'h00);
    endtask

    task automatic t_holes();
        set_bank(4'hE); core_wr(0, 8'h00, 8'h77); core_rd(0, 8'h00);
        check("R4 hole 0xE00", core_rdata, 8'h00);
        set_bank(4'hF); core_wr(0, 8'h5F, 8'h66); core_rd(0, 8'h5F);
        check("R4 hole 0xF5F", core_rdata, 8'h00);
        usb_en = 1; dma_wr(12'hE10, 8'h55); dma_rd(12'hE10);
        check("R8 DMA outside RAM", dma_rdata, 8'h00);
        usb_en = 0;
    endtask

    task automatic t_bsr();
        set_bank(4'h9); core_rd(1, 8'hE0);
        check("R5 load readback", core_rdata, 8'h09);
        core_wr(1, 8'hE0, 8'hFC); core_rd(1, 8'hE0);
        check("R5 bus write low nibble", core_rdata, 8'h0C);
        bsr_ld = 1; bsr_in = 4'h5; core_wr(1, 8'hE0, 8'h0A); core_rd(1, 8'hE0);
        check("R5 strobe beats bus write", core_rdata, 8'h05);
    endtask

    task automatic t_timing();
        set_bank(4'h2); core_wr(0, 8'h40, 8'hB7);
        check("R7 write visible same edge", core_rdata, 8'hB7);
        core_opnd = 8'h41; core_acc = 1; tick(); tick();
        check("R7 address held", core_rdata, 8'hB7);
    endtask

    task automatic t_dma();
        usb_en = 1; set_bank(4'h1);
        core_en = 1; core_we = 1; core_acc = 0; core_opnd = 8'h01; core_wdata = 8'hC3;
        dma_en = 1; dma_we = 1; dma_addr = 12'h100; dma_wdata = 8'h3C; tick();
        check("R10 no conflict on distinct addresses", {7'b0, core_conflict}, 8'h00);
        core_rd(0, 8'h00);
        check("R8 DMA write seen by core", core_rdata, 8'h3C);
        dma_rd(12'h101);
        check("R8 core write seen by DMA", dma_rdata, 8'hC3);
        usb_en = 0;
    endtask

    task automatic t_usb_off();
        usb_en = 0; set_bank(4'h2); core_wr(0, 8'h00, 8'h12);
        dma_wr(12'h200, 8'h44); core_rd(0, 8'h00);
        check("R9 DMA write ignored", core_rdata, 8'h12);
        dma_rd(12'h200);
        check("R9 DMA read zero", dma_rdata, 8'h00);
    endtask

    task automatic t_conflict();
        usb_en = 1; set_bank(4'h0);
        core_en = 1; core_we = 1; core_acc = 0; core_opnd = 8'h50; core_wdata = 8'hAA;
        dma_en = 1; dma_we = 1; dma_addr = 12'h050; dma_wdata = 8'h55; tick();
        check("R10 conflict flag", {7'b0, core_conflict}, 8'h01);
        check("R10 DMA byte stored", core_rdata, 8'h55);
        tick();
        check("R10 flag one cycle", {7'b0, core_conflict}, 8'h00);
        usb_en = 0;
    endtask

    task automatic t_desc();
        usb_en = 0; set_bank(4'hD); core_wr(0, 8'h10, 8'h61);
        check("R11 plain RAM when USB off", core_rdata, 8'h61);
        usb_en = 1; core_wr(0, 8'h10, 8'h62);
        check("R11 core write blocked", core_rdata, 8'h61);
        dma_wr(12'hD10, 8'h70); core_rd(0, 8'h10);
        check("R11 DMA writes descriptor", core_rdata, 8'h70);
        usb_en = 0; core_wr(0, 8'h10, 8'h63);
        check("R11 RAM again when USB off", core_rdata, 8'h63);
    endtask

    initial begin
        rst_n = 0; core_en = 0; core_we = 0; core_acc = 0; core_opnd = 0; core_wdata = 0;
        bsr_ld = 0; bsr_in = 0; usb_en = 0; dma_en = 0; dma_we = 0; dma_addr = 0; dma_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_banked();
        t_win_low();
        t_win_high();
        t_holes();
        t_bsr();
        t_timing();
        t_dma();
        t_usb_off();
        t_conflict();
        t_desc();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule